// File: doc/BRIEF.md
# Audio Sample FIFO with Threshold Request

This block buffers audio words for one audio sub-block. A single direction input chooses how the buffer is used. In transmit use, software fills the buffer and the serializer drains it. In receive use, the serializer fills it and software drains it. The storage and the ports are the same in both cases. Only the meaning of the request output changes with the direction.

The block reports its fill as a coarse 3-bit code in quarter steps of the depth. It compares that code with a 3-bit threshold code to produce one request flag. The flag is combinational, is set and cleared by the hardware alone, and needs no acknowledge. An interrupt output is the request qualified by an enable input.

Errors are recorded in sticky flags. A write into a full buffer or a read from an empty one is dropped and sets its flag. A dedicated input clears both flags, and a flush input empties the buffer in one cycle.

Top module: `audio_fill_fifo`

## Requirements
- R1: After a synchronous active-low reset, the buffer is empty, `fill_code` is 000, `ovr_err` and `udr_err` are 0, and `req` follows R4/R5 for the current configuration.
- R2: Accepted words leave in write order; while the buffer is not empty, `rd_data` shows the oldest stored word, and an accepted read advances to the next one.
- R3: With `quarter` = DEPTH/4 and `n` the number of stored words, `fill_code` is 000 when n=0, 001 when 0<n<quarter, 010 when quarter<=n<2·quarter, 011 when 2·quarter<=n<3·quarter, 100 when 3·quarter<=n<DEPTH, and 101 when n=DEPTH.
- R4: With `rx_mode`=0, `req` is 1 exactly when `fill_code` <= the threshold code (000 empty, 001 quarter, 010 half, 011 three quarters, 100 full). So code 000 requests only while the buffer is empty, and code 100 requests until the buffer is full.
- R5: With `rx_mode`=1, `req` is 1 exactly when `fill_code` > the threshold code. So code 000 requests whenever at least one word is stored.
- R6: Threshold codes 101, 110 and 111 behave as code 100.
- R7: `irq` equals `req` when `irq_en`=1 and is 0 when `irq_en`=0.
- R8: A write while the buffer is full is dropped, and `ovr_err` is set from the next cycle until it is cleared.
- R9: A read while the buffer is empty is dropped and does not move the buffer, and `udr_err` is set from the next cycle until it is cleared.
- R10: `err_clr` clears both sticky flags on the next cycle. An error event in the same cycle as `err_clr` sets its flag regardless.
- R11: `flush` empties the buffer in one cycle, so `fill_code` is 000 on the next cycle. Reads and writes in the flush cycle are dropped and set no error flag.
- R12: A read and a write in the same cycle on a buffer that is neither empty nor full are both accepted, and the fill is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_mode | input | 1 | 0 = transmit buffer, 1 = receive buffer |
| thr_code | input | 3 | Request threshold code |
| irq_en | input | 1 | Interrupt enable |
| flush | input | 1 | Empty the buffer |
| err_clr | input | 1 | Clear the sticky error flags |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write word |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Oldest stored word (valid when not empty) |
| fill_code | output | 3 | Quantized fill level |
| req | output | 1 | Threshold request |
| irq | output | 1 | Request gated by enable |
| ovr_err | output | 1 | Sticky write-when-full flag |
| udr_err | output | 1 | Sticky read-when-empty flag |

## Verification
The bench builds the block with its defaults, DEPTH=8 and DATA_W=32, so each quarter is two words. Eight writes therefore reach every fill code, and each boundary between two codes is one word away from the next. At this size a directed sweep can cover every combination of threshold code, fill code and direction, including the reserved threshold codes. The random phase that follows also runs often into both the full and the empty edges, which exercises the error flags and the simultaneous read-and-write case.

// File: rtl/audio_fifo_pkg.sv
// Shared types for the audio sample FIFO.
// Assumes a depth that is a power of two and a multiple of four.
package audio_fifo_pkg;

    typedef enum logic [2:0] {
        FILL_NONE  = 3'd0,
        FILL_LOW   = 3'd1,
        FILL_QTR   = 3'd2,
        FILL_HALF  = 3'd3,
        FILL_3QTR  = 3'd4,
        FILL_FULL  = 3'd5
    } fill_code_t;

    localparam logic [2:0] THR_MAX = 3'd4;

endpackage

// File: rtl/afifo_store.sv
// Circular word storage with pointers, occupancy count and sticky error flags.
// Assumes DEPTH is a power of two. Flush has priority over reads and writes.
// Acceptance uses the count from before the edge.
module afifo_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              err_clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [CW-1:0]     count,
    output logic              ovr_err,
    output logic              udr_err
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp, rp;
    logic              is_full, is_empty;
    logic              wr_ok, rd_ok, ovr_ev, udr_ev;

    // Status of the buffer and acceptance of this cycle's strobes.
    always_comb begin
        is_full  = (count == CW'(DEPTH));
        is_empty = (count == '0);
        wr_ok    = wr_en && !is_full  && !flush;
        rd_ok    = rd_en && !is_empty && !flush;
        ovr_ev   = wr_en &&  is_full  && !flush;
        udr_ev   = rd_en &&  is_empty && !flush;
    end

    // Word storage, written at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wp] <= wr_data;
    end

    assign rd_data = mem[rp];

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (wr_ok) wp <= wp + 1'b1;
            if (rd_ok) rp <= rp + 1'b1;
            if (wr_ok && !rd_ok)      count <= count + 1'b1;
            else if (rd_ok && !wr_ok) count <= count - 1'b1;
        end
    end

    // Sticky error flags; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_err <= 1'b0;
            udr_err <= 1'b0;
        end else begin
            if (ovr_ev)       ovr_err <= 1'b1;
            else if (err_clr) ovr_err <= 1'b0;
            if (udr_ev)       udr_err <= 1'b1;
            else if (err_clr) udr_err <= 1'b0;
        end
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    p_full_write_dropped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && wr_en && !rd_en && !flush) |=> (count == CW'(DEPTH)) && ovr_err);

    p_empty_read_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_empty && rd_en && !wr_en && !flush) |=> (count == '0) && udr_err);

    p_flush_empties_r11: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));

    p_both_keep_count_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && !is_full && !is_empty && !flush) |=> $stable(count));

endmodule

// File: rtl/afifo_fill_quant.sv
// Maps the occupancy count to a quarter-step fill code.
// Assumes DEPTH is a multiple of four.
module afifo_fill_quant
    import audio_fifo_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int QTR  = DEPTH / 4
) (
    input  logic [CW-1:0] count,
    output fill_code_t    code
);

    // Pick the band the count falls into.
    always_comb begin
        if (count == '0)                 code = FILL_NONE;
        else if (count == CW'(DEPTH))    code = FILL_FULL;
        else if (count <  CW'(QTR))      code = FILL_LOW;
        else if (count <  CW'(2 * QTR))  code = FILL_QTR;
        else if (count <  CW'(3 * QTR))  code = FILL_HALF;
        else                             code = FILL_3QTR;
    end

endmodule

// File: rtl/afifo_req_gen.sv
// Compares the fill code with the threshold code to form the request.
// Transmit requests at or below the threshold, receive above it.
// Reserved threshold codes clamp to the full code.
module afifo_req_gen
    import audio_fifo_pkg::*;
(
    input  fill_code_t code,
    input  logic [2:0] thr,
    input  logic       rx_mode,
    output logic       req
);

    logic [2:0] thr_eff;

    // Clamp the threshold, then apply the direction's comparison.
    always_comb begin
        thr_eff = (thr > THR_MAX) ? THR_MAX : thr;
        req     = rx_mode ? (3'(code) > thr_eff) : (3'(code) <= thr_eff);
    end

endmodule

// File: rtl/audio_fill_fifo.sv
// Audio sample FIFO for one sub-block, with a quantized fill code and a
// threshold request whose sense depends on the direction.
// Assumes DEPTH is a power of two and a multiple of four.
module audio_fill_fifo
    import audio_fifo_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_mode,
    input  logic [2:0]        thr_code,
    input  logic              irq_en,
    input  logic              flush,
    input  logic              err_clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [2:0]        fill_code,
    output logic              req,
    output logic              irq,
    output logic              ovr_err,
    output logic              udr_err
);

    logic [CW-1:0] count;
    fill_code_t    code;

    afifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .err_clr(err_clr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .count(count), .ovr_err(ovr_err), .udr_err(udr_err)
    );

    afifo_fill_quant #(.DEPTH(DEPTH)) u_quant (.count(count), .code(code));

    afifo_req_gen u_req (.code(code), .thr(thr_code), .rx_mode(rx_mode), .req(req));

    assign fill_code = code;
    assign irq       = req & irq_en;

    p_full_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH)) == (fill_code == 3'd5));

    p_rx_needs_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_mode && req) |-> (count != '0));

    p_tx_full_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_mode && count == CW'(DEPTH)) |-> !req);

    p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && count <= CW'(DEPTH)));

endmodule

// File: tb/tb_audio_fill_fifo.sv
`timescale 1ns/1ps
module tb_audio_fill_fifo;

    localparam int DW  = 32;
    localparam int DEP = 8;
    localparam realtime TCK = 4.0;

    logic          clk = 1'b0;
    logic          rst_n, rx_mode, irq_en, flush, err_clr, wr_en, rd_en;
    logic [2:0]    thr_code;
    logic [DW-1:0] wr_data, rd_data;
    logic [2:0]    fill_code;
    logic          req, irq, ovr_err, udr_err;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    logic [DW-1:0] mq[$];
    bit m_ovr, m_udr;

    always #(TCK/2) clk = ~clk;

    audio_fill_fifo #(.DATA_W(DW), .DEPTH(DEP)) dut (
        .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode), .thr_code(thr_code),
        .irq_en(irq_en), .flush(flush), .err_clr(err_clr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .fill_code(fill_code), .req(req), .irq(irq),
        .ovr_err(ovr_err), .udr_err(udr_err)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] exp_code(int n);
        if (n == 0)   return 3'd0;
        if (n == DEP) return 3'd5;
        return 3'(1 + n / 2);
    endfunction

    function automatic bit exp_req(int n, bit rx, logic [2:0] t);
        int lim;
        int tt = (t > 3'd4) ? 4 : int'(t);
        if (!rx) begin
            lim = (tt == 0) ? 1 : 2 * tt;
            return n < lim;
        end
        lim = (tt == 0) ? 1 : 2 * tt;
        return n >= lim;
    endfunction

    // Reference update for one clock edge.
    task automatic model_edge();
        int sz = mq.size();
        if (!rst_n) begin
            mq.delete(); m_ovr = 0; m_udr = 0;
            return;
        end
        if (flush) begin
            mq.delete();
            if (err_clr) begin m_ovr = 0; m_udr = 0; end
            return;
        end
        if (wr_en && sz == DEP) m_ovr = 1; else if (err_clr) m_ovr = 0;
        if (rd_en && sz == 0)   m_udr = 1; else if (err_clr) m_udr = 0;
        if (rd_en && sz > 0)    void'(mq.pop_front());
        if (wr_en && sz < DEP)  mq.push_back(wr_data);
    endtask

    task automatic compare_all();
        bit er = exp_req(mq.size(), rx_mode, thr_code);
        chk("R3 fill_code", 32'(fill_code), 32'(exp_code(mq.size())));
        if (thr_code > 3'd4)  chk("R6 req", 32'(req), 32'(er));
        else if (rx_mode)     chk("R5 req", 32'(req), 32'(er));
        else                  chk("R4 req", 32'(req), 32'(er));
        chk("R7 irq", 32'(irq), 32'(er & irq_en));
        chk("R8 ovr_err", 32'(ovr_err), 32'(m_ovr));
        chk("R9 udr_err", 32'(udr_err), 32'(m_udr));
        if (mq.size() > 0) chk("R2 rd_data", rd_data, mq[0]);
    endtask

    task automatic step(input bit w, input bit r, input bit fl = 0, input bit clr = 0);
        wr_en = w; rd_en = r; flush = fl; err_clr = clr;
        wr_data = $urandom;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
        wr_en = 0; rd_en = 0; flush = 0; err_clr = 0;
    endtask

    initial begin
        rst_n = 0; rx_mode = 0; thr_code = 0; irq_en = 1;
        flush = 0; err_clr = 0; wr_en = 0; rd_en = 0; wr_data = '0;
        repeat (3) begin @(posedge clk); model_edge(); end
        @(negedge clk); rst_n = 1;
        // R1: reset state
        chk("R1 fill_code", 32'(fill_code), 0);
        chk("R1 ovr_err", 32'(ovr_err), 0);
        chk("R1 udr_err", 32'(udr_err), 0);
        chk("R1 req", 32'(req), 1);

        // Sweep every threshold and fill in both directions.
        for (int d = 0; d < 2; d++) begin
            rx_mode = d[0];
            for (int t = 0; t < 8; t++) begin
                thr_code = 3'(t);
                irq_en = t[0];
                for (int k = 0; k < DEP; k++) step(1, 0);
                for (int k = 0; k < DEP; k++) step(0, 1);
            end
        end

        // R8: overrun, R10: clear, then event beats clear.
        for (int k = 0; k < DEP; k++) step(1, 0);
        step(1, 0);
        chk("R8 ovr set", 32'(ovr_err), 1);
        step(0, 0, 0, 1);
        chk("R10 ovr cleared", 32'(ovr_err), 0);
        step(1, 0, 0, 1);
        chk("R10 event wins", 32'(ovr_err), 1);

        // R12: simultaneous read and write keep fill.
        step(0, 1);
        step(1, 1);
        chk("R12 fill kept", 32'(fill_code), 32'(exp_code(DEP - 1)));

        // R11: flush with strobes, no flags.
        step(0, 0, 0, 1);
        step(1, 1, 1, 0);
        chk("R11 flushed", 32'(fill_code), 0);
        chk("R11 no ovr", 32'(ovr_err), 0);
        step(0, 1);
        chk("R9 udr set", 32'(udr_err), 1);
        step(0, 1, 0, 1);
        chk("R10 udr event wins", 32'(udr_err), 1);
        step(0, 0, 0, 1);

        // Random traffic.
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(0, 31) == 0) begin
                rx_mode = $urandom; thr_code = $urandom; irq_en = $urandom;
            end
            step($urandom_range(0, 1), $urandom_range(0, 1),
                 $urandom_range(0, 99) == 0, $urandom_range(0, 19) == 0);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(TCK * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule